// File: doc/BRIEF.md
# Compare Timer Channel with Selectable Output Flag

This block is one channel of a multi-channel counter/timer. A counter steps up or down by one on each qualified count tick. When a step lands on the active compare value, the channel raises a one-cycle compare event. On the next clock edge it reloads the counter from a load value.

The output flag is driven in one of eight modes. It can follow the counting state. It can be cleared, set or toggled on a compare. It can toggle while the compare target alternates between two registers. It can be set on a compare and cleared either by a secondary input edge or by a counter wrap. It can also carry a gated copy of the clock.

Sibling channels can force a reload through their compare events, provided this channel allows it. A count-once option halts the channel after its first compare-driven reload. A control-write strobe re-arms it.

Top module: `cmp_timer_chan`

## Requirements
- R1: With dir_i=0 the counter rises by one on each clock edge where tick_i is high and the channel is counting. With dir_i=1 it falls by one. Without a tick it holds.
- R2: While rst_n is low, cnt_o is 0, cmp_evt_o is 0 and the stored flag is 0. After reset the channel is counting and its compare target is cmp1_i.
- R3: If a counting step produces the active target, cmp_evt_o is high for exactly the following cycle, with cnt_o showing the target. At the edge that ends that cycle, cnt_o takes load_i.
- R4: If ext_init_en_i=1 and any bit of sib_cmp_i is high at an edge, cnt_o takes load_i at that edge. If ext_init_en_i=0, sib_cmp_i has no effect on the count.
- R5: Counting up from all ones gives 0, and counting down from 0 gives all ones. Each such wrap produces an internal one-cycle wrap pulse in the following cycle.
- R6: In output mode 3'b000, oflag_o is high exactly while the channel is counting.
- R7: In modes 3'b001, 3'b010 and 3'b011, the flag is cleared, set or inverted, respectively, at the edge that ends a compare-event cycle.
- R8: In mode 3'b100, the target starts at cmp1_i and swaps between cmp1_i and cmp2_i after each compare-driven reload. The flag inverts on every compare.
- R9: In mode 3'b101, a compare sets the flag. A rising edge of sec_i clears it at the third clock edge after sec_i rises, because sec_i passes through two synchronizer flops. If both happen at once, the set wins.
- R10: In mode 3'b110, a compare sets the flag. It is cleared at the edge that ends the wrap pulse cycle. If both happen at once, the set wins.
- R11: In mode 3'b111, oflag_o equals clk AND the counting state.
- R12: With once_i=1, the channel stops counting after its first compare-driven reload and ignores ticks. A high ctl_wr_i at an edge re-arms it and resets the target to cmp1_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Qualified count tick |
| sec_i | input | 1 | Asynchronous secondary input |
| dir_i | input | 1 | 0 counts up, 1 counts down |
| ext_init_en_i | input | 1 | Allow sibling compares to force a reload |
| omode_i | input | 3 | Output flag mode |
| once_i | input | 1 | Stop after the first compare reload |
| ctl_wr_i | input | 1 | Control rewrite strobe, re-arms the channel |
| cmp1_i | input | CNT_W | First compare value |
| cmp2_i | input | CNT_W | Second compare value (alternating mode) |
| load_i | input | CNT_W | Reload value |
| sib_cmp_i | input | N_SIB | Compare events of sibling channels |
| cnt_o | output | CNT_W | Counter value |
| cmp_evt_o | output | 1 | One-cycle compare event |
| oflag_o | output | 1 | Output flag |

## Verification
The bench sweeps all eight modes in both directions. It uses compare windows that need a wrap to reach, and it overlaps own compares with sibling reloads, secondary edges and wraps. A design that compared the pre-step value, or that let a sibling request through while disabled, would drift from the arithmetic reference count within a few ticks.

A design that let clear win over set in modes 101 and 110, or that skipped a synchronizer stage, would show the flag one cycle off or in the wrong state. A design that failed to swap targets in mode 100, or that kept counting after a count-once stop, would put the compare event in the wrong cycle.

// File: rtl/cmp_timer_pkg.sv
// Shared definitions for the compare timer channel.
package cmp_timer_pkg;
    // Output flag modes; the encoding is the value driven on omode_i.
    typedef enum logic [2:0] {
        OM_ACTIVE   = 3'd0,
        OM_CLR      = 3'd1,
        OM_SET      = 3'd2,
        OM_TOG      = 3'd3,
        OM_ALT      = 3'd4,
        OM_SET_SEC  = 3'd5,
        OM_SET_ROLL = 3'd6,
        OM_GATED    = 3'd7
    } omode_e;
endpackage

// File: rtl/ctm_sec_sync.sv
// Synchronizes the asynchronous secondary input and flags its rising edge.
// Assumes sec_i may change at any time; the edge pulse lasts one cycle.
module ctm_sec_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_i,
    output logic rise_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[CHAIN_W-2:0], sec_i};
    end

    // Rising edge seen at the synchronized output.
    always_comb rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/ctm_counter.sv
// Counter, compare and reload core of one timer channel.
// A compare event is registered when a counting step lands on the target.
// The reload follows at the next edge. Assumes alternating mode is not
// combined with count-once.
module ctm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             dir_i,
    input  logic             once_i,
    input  logic             ctl_wr_i,
    input  logic             alt_mode_i,
    input  logic             ext_req_i,
    input  logic [CNT_W-1:0] cmp1_i,
    input  logic [CNT_W-1:0] cmp2_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_o,
    output logic             roll_o,
    output logic             act_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, step_val, target;
    logic             evt_q, roll_q, sel_q, act_q, wrap, reload;

    // Candidate next value and the wrap it would cause.
    always_comb begin
        step_val = dir_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
        wrap     = dir_i ? (cnt_q == '0) : (cnt_q == ALL_ONES);
        target   = (alt_mode_i && sel_q) ? cmp2_i : cmp1_i;
        reload   = evt_q | ext_req_i;
    end

    // Count, reload, and register the compare and wrap pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            evt_q  <= 1'b0;
            roll_q <= 1'b0;
        end else begin
            evt_q  <= 1'b0;
            roll_q <= 1'b0;
            if (reload) begin
                cnt_q <= load_i;
            end else if (act_q && tick_i) begin
                cnt_q  <= step_val;
                evt_q  <= (step_val == target);
                roll_q <= wrap;
            end
        end
    end

    // Counting state: cleared by a count-once reload, set by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= 1'b1;
        else if (ctl_wr_i)
            act_q <= 1'b1;
        else if (evt_q && once_i)
            act_q <= 1'b0;
    end

    // Alternating target selector, swapped after each own compare.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else if (ctl_wr_i || !alt_mode_i)
            sel_q <= 1'b0;
        else if (evt_q)
            sel_q <= ~sel_q;
    end

    assign cnt_o  = cnt_q;
    assign evt_o  = evt_q;
    assign roll_o = roll_q;
    assign act_o  = act_q;
endmodule

// File: rtl/ctm_flag.sv
// Output flag generator for the eight output modes.
// Assumes evt_i, roll_i and sec_rise_i are one-cycle pulses.
module ctm_flag
    import cmp_timer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  omode_e mode_i,
    input  logic   evt_i,
    input  logic   roll_i,
    input  logic   sec_rise_i,
    input  logic   act_i,
    output logic   flag_o
);
    logic flag_q;

    // Stored flag update; a compare set wins over any clear source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            case (mode_i)
                OM_CLR:      if (evt_i) flag_q <= 1'b0;
                OM_SET:      if (evt_i) flag_q <= 1'b1;
                OM_TOG,
                OM_ALT:      if (evt_i) flag_q <= ~flag_q;
                OM_SET_SEC:  if (evt_i) flag_q <= 1'b1;
                             else if (sec_rise_i) flag_q <= 1'b0;
                OM_SET_ROLL: if (evt_i) flag_q <= 1'b1;
                             else if (roll_i) flag_q <= 1'b0;
                default:     flag_q <= flag_q;
            endcase
        end
    end

    // Output selection: counting state, gated clock or stored flag.
    always_comb begin
        case (mode_i)
            OM_ACTIVE: flag_o = act_i;
            OM_GATED:  flag_o = clk & act_i;
            default:   flag_o = flag_q;
        endcase
    end
endmodule

// File: rtl/cmp_timer_chan.sv
// One compare timer channel: counter core, secondary input synchronizer
// and output flag generator. Sibling compare events reload the counter
// when ext_init_en_i allows it.
module cmp_timer_chan
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int N_SIB       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sec_i,
    input  logic             dir_i,
    input  logic             ext_init_en_i,
    input  logic [2:0]       omode_i,
    input  logic             once_i,
    input  logic             ctl_wr_i,
    input  logic [CNT_W-1:0] cmp1_i,
    input  logic [CNT_W-1:0] cmp2_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [N_SIB-1:0] sib_cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cmp_evt_o,
    output logic             oflag_o
);
    omode_e mode;
    logic   ext_req, roll_w, act_w, sec_rise;

    // Decode the mode field and qualify sibling reload requests.
    always_comb begin
        mode    = omode_e'(omode_i);
        ext_req = ext_init_en_i & (|sib_cmp_i);
    end

    ctm_sec_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sec_i  (sec_i),
        .rise_o (sec_rise)
    );

    ctm_counter #(.CNT_W(CNT_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .dir_i      (dir_i),
        .once_i     (once_i),
        .ctl_wr_i   (ctl_wr_i),
        .alt_mode_i (mode == OM_ALT),
        .ext_req_i  (ext_req),
        .cmp1_i     (cmp1_i),
        .cmp2_i     (cmp2_i),
        .load_i     (load_i),
        .cnt_o      (cnt_o),
        .evt_o      (cmp_evt_o),
        .roll_o     (roll_w),
        .act_o      (act_w)
    );

    ctm_flag flag_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .evt_i      (cmp_evt_o),
        .roll_i     (roll_w),
        .sec_rise_i (sec_rise),
        .act_i      (act_w),
        .flag_o     (oflag_o)
    );
endmodule

// File: rtl/cmp_timer_chan_chk.sv
// Protocol checker for cmp_timer_chan, attached by bind.
module cmp_timer_chan_chk #(
    parameter int CNT_W = 16,
    parameter int N_SIB = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             dir_i,
    input logic             ext_init_en_i,
    input logic [2:0]       omode_i,
    input logic [CNT_W-1:0] load_i,
    input logic [N_SIB-1:0] sib_cmp_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             cmp_evt_o,
    input logic             oflag_o,
    input logic             act_w,
    input logic             roll_w
);
    logic ext_seen;
    assign ext_seen = ext_init_en_i && (|sib_cmp_i);

    assert_count_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w && tick_i && !cmp_evt_o && !ext_seen && !dir_i)
        |=> cnt_o == $past(cnt_o) + 1'b1);

    assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w && tick_i && !cmp_evt_o && !ext_seen && dir_i)
        |=> cnt_o == $past(cnt_o) - 1'b1);

    assert_evt_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt_o |=> (cnt_o == $past(load_i)) && !cmp_evt_o);

    assert_sib_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_seen |=> cnt_o == $past(load_i));

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt_o && omode_i == 3'd1) |=> (omode_i != 3'd1) || !oflag_o);

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt_o && omode_i == 3'd2) |=> (omode_i != 3'd2) || oflag_o);

    assert_flag_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt_o && omode_i == 3'd4)
        |=> (omode_i != 3'd4) || (oflag_o != $past(oflag_o)));

    assert_roll_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_w && !cmp_evt_o && omode_i == 3'd6) |=> (omode_i != 3'd6) || !oflag_o);

    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_w && !ext_seen && !cmp_evt_o) |=> $stable(cnt_o));
endmodule

bind cmp_timer_chan cmp_timer_chan_chk #(.CNT_W(CNT_W), .N_SIB(N_SIB)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .dir_i         (dir_i),
    .ext_init_en_i (ext_init_en_i),
    .omode_i       (omode_i),
    .load_i        (load_i),
    .sib_cmp_i     (sib_cmp_i),
    .cnt_o         (cnt_o),
    .cmp_evt_o     (cmp_evt_o),
    .oflag_o       (oflag_o),
    .act_w         (act_w),
    .roll_w        (roll_w)
);

// File: tb/cmp_timer_chan_tb_top.sv
// Sweeps modes, directions and compare windows against an arithmetic reference.
module cmp_timer_chan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TB_W       = 8;
    localparam int TB_SIB     = 2;

    logic              clk = 1'b0;
    logic              rst_n, tick_i, sec_i, dir_i, ext_init_en_i, once_i, ctl_wr_i;
    logic [2:0]        omode_i;
    logic [TB_W-1:0]   cmp1_i, cmp2_i, load_i, cnt_o;
    logic [TB_SIB-1:0] sib_cmp_i;
    logic              cmp_evt_o, oflag_o;

    int tests = 0;
    int fails = 0;

    // Reference state
    logic [TB_W-1:0] m_cnt;
    logic m_evt, m_roll, m_sel, m_act, m_flag;
    logic [2:0] m_sync;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer_chan #(.CNT_W(TB_W), .N_SIB(TB_SIB)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sec_i(sec_i), .dir_i(dir_i),
        .ext_init_en_i(ext_init_en_i), .omode_i(omode_i), .once_i(once_i),
        .ctl_wr_i(ctl_wr_i), .cmp1_i(cmp1_i), .cmp2_i(cmp2_i), .load_i(load_i),
        .sib_cmp_i(sib_cmp_i), .cnt_o(cnt_o), .cmp_evt_o(cmp_evt_o), .oflag_o(oflag_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the reference by one edge using the inputs currently driven.
    task automatic model_edge();
        logic ext, rise, nflag, nact, nsel, nevt, nroll, wrap;
        logic [TB_W-1:0] tgt, nxt, ncnt;
        ext   = ext_init_en_i & (|sib_cmp_i);
        rise  = m_sync[1] & ~m_sync[2];
        nflag = m_flag;
        case (omode_i)
            3'd1: if (m_evt) nflag = 1'b0;
            3'd2: if (m_evt) nflag = 1'b1;
            3'd3, 3'd4: if (m_evt) nflag = ~m_flag;
            3'd5: if (m_evt) nflag = 1'b1; else if (rise) nflag = 1'b0;
            3'd6: if (m_evt) nflag = 1'b1; else if (m_roll) nflag = 1'b0;
            default: ;
        endcase
        tgt  = (omode_i == 3'd4 && m_sel) ? cmp2_i : cmp1_i;
        nact = ctl_wr_i ? 1'b1 : ((m_evt && once_i) ? 1'b0 : m_act);
        nsel = (ctl_wr_i || omode_i != 3'd4) ? 1'b0 : (m_evt ? ~m_sel : m_sel);
        nxt  = dir_i ? m_cnt - 1'b1 : m_cnt + 1'b1;
        wrap = dir_i ? (m_cnt == 0) : (m_cnt == {TB_W{1'b1}});
        ncnt = m_cnt; nevt = 1'b0; nroll = 1'b0;
        if (m_evt || ext) ncnt = load_i;
        else if (m_act && tick_i) begin
            ncnt = nxt; nevt = (nxt == tgt); nroll = wrap;
        end
        m_sync = {m_sync[1:0], sec_i};
        m_cnt = ncnt; m_evt = nevt; m_roll = nroll;
        m_act = nact; m_sel = nsel; m_flag = nflag;
    endtask

    function automatic string flag_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R6";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            3'd7: return "R11";
            default: return "R7";
        endcase
    endfunction

    // One clock: drive, edge, reference update, then checks in both phases.
    task automatic step(input logic tk, input logic sc, input logic [TB_SIB-1:0] sb,
                        input logic cw, input string cnt_tag);
        tick_i = tk; sec_i = sc; sib_cmp_i = sb; ctl_wr_i = cw;
        @(posedge clk);
        model_edge();
        #2;
        if (omode_i == 3'd7) chk("R11 gated high phase", oflag_o, m_act);
        @(negedge clk);
        #1;
        chk(cnt_tag, cnt_o, m_cnt);
        chk("R3", cmp_evt_o, m_evt);
        chk(flag_tag(omode_i), oflag_o,
            (omode_i == 3'd0) ? m_act : ((omode_i == 3'd7) ? 1'b0 : m_flag));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic sc;
        rst_n = 1'b0; tick_i = 1'b0; sec_i = 1'b0; dir_i = 1'b0; ext_init_en_i = 1'b0;
        once_i = 1'b0; ctl_wr_i = 1'b0; omode_i = 3'd2; cmp1_i = '0; cmp2_i = '0;
        load_i = '0; sib_cmp_i = '0;
        m_cnt = '0; m_evt = 0; m_roll = 0; m_sel = 0; m_act = 1; m_flag = 0; m_sync = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R2 reset count", cnt_o, 0);
        chk("R2 reset event", cmp_evt_o, 0);
        chk("R2 reset flag", oflag_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        sc = 1'b0;
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int v = 0; v < 3; v++) begin
                    if (m == 4 && v == 2) continue;
                    omode_i = 3'(m);
                    dir_i   = d[0];
                    once_i  = (v == 2);
                    if (d == 0) begin
                        load_i = (v == 1) ? 8'hFC : 8'h05;
                        cmp1_i = (v == 1) ? 8'h03 : 8'h0C;
                        cmp2_i = (v == 1) ? 8'hFE : 8'h09;
                    end else begin
                        load_i = (v == 1) ? 8'h03 : 8'h12;
                        cmp1_i = (v == 1) ? 8'hFA : 8'h08;
                        cmp2_i = (v == 1) ? 8'h01 : 8'h0B;
                    end
                    ext_init_en_i = 1'b1;
                    step(1'b0, sc, 2'b01, 1'b1, "R4 segment load");
                    ext_init_en_i = ((m + v) % 2) == 0;
                    for (int s = 0; s < 70; s++) begin
                        logic [TB_SIB-1:0] sb;
                        string tg;
                        if (($urandom % 6) == 0) sc = ~sc;
                        sb = (($urandom % 14) == 0) ? TB_SIB'($urandom % 3 + 1) : '0;
                        if (v == 2) tg = "R12";
                        else if (sb != 0) tg = ext_init_en_i ? "R4" : "R4 ignored";
                        else if (v == 1) tg = "R5";
                        else tg = "R1";
                        step(($urandom % 4) != 0, sc, sb, (v == 2 && s == 40), tg);
                    end
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule